// File: doc/BRIEF.md
# Multi-channel interrupt multiplexer

This block takes one shared set of level-sensitive interrupt lines and fans it out to several independent channels. Each channel applies its own enable mask to the lines and raises one active-high interrupt output while any enabled line is high. Sources may be asynchronous to the bus clock, so each line first passes through a two-flop synchroniser. After that, every channel sees the same synchronised copy.

Software controls the block over a plain 32-bit register bus. Each channel has a read/write enable register and a read-only pending register, and each channel's pair sits in its own 0x40-byte window. Interrupts clear themselves: a line stays pending while it is high, and it stops being pending when it goes low. A handler therefore reads the pending register of its channel, services the sources it finds, and writes nothing back. Writing zero to a channel's enable register silences that channel completely.

Top module: `irq_fanout_mux`

## Requirements
- R1: There are 8 channels. Channel n has a 32-bit enable register at byte address 0x10 + 0x40*n. Bit k of that register enables source k for channel n. The register resets to zero. A write updates it at the write edge, and a read returns the last value written.
- R2: Channel n has a read-only pending register at byte address 0x20 + 0x40*n. Bit k of that register reads as 1 exactly when the synchronised copy of source k is high and bit k of channel n's enable register is set.
- R3: A source passes through two synchronising flops, and the channel output adds one more register. A rise on a source that arrives before clock edge 1 therefore shows on an enabled channel's output only after edge 3.
- R4: irq_out[n] is a registered OR of channel n's pending bits and is active high. A change in an enable register at one edge reaches the output at the following edge.
- R5: Writing zero to a channel's enable register clears every pending bit of that channel. The channel's output is low after the edge that follows the write edge.
- R6: Sources are level-sensitive. The output stays high while an enabled source stays high, and it falls three edges after the last enabled source falls, with no write needed to clear it.
- R7: Writes to pending addresses, to unmapped offsets, and to addresses whose two low bits are not zero change no register. Reads of such unmapped addresses return zero. rdata is loaded at the edge where rd_en is high and is valid after that edge. rdata is zero after any edge where rd_en is low.
- R8: After reset all enable registers are zero, all outputs are low, and rdata is zero.
- R9: A write to one channel's enable register does not change any other channel's enable register, pending register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32 | Level-sensitive interrupt sources, active high, may be asynchronous |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Register read strobe, data valid after the next edge |
| addr | input | 9 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 8 | One interrupt output per channel |

## Verification
The hardest case to reach from the ports is the pipeline timing. A source edge, an enable change and a read can all meet in the same few cycles. The two synchroniser stages and the output register then hold different pictures of the same source.

The directed part of the bench counts edges exactly. It raises one source and checks the output after two edges and after three edges. It also disables a channel whose source is still high. A randomised phase then toggles every source line on every cycle, while writes and reads hit random channels with masks that are often zero. A behavioural three-stage model follows those overlaps cycle by cycle.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_EN   = 2'd1,
    REG_PEND = 2'd2
  } reg_kind_e;

  // Classify a byte address as an enable register, a pending register or unmapped.
  function automatic reg_kind_e decode_kind(input logic [31:0] a, input int num_ch,
                                            input int stride, input int en_ofs,
                                            input int pend_ofs);
    int unsigned ai;
    int unsigned ch;
    int unsigned ofs;
    reg_kind_e   k;
    ai  = a;
    ch  = ai / stride;
    ofs = ai % stride;
    k   = REG_NONE;
    if (a[1:0] == 2'b00 && ch < num_ch) begin
      if (ofs == en_ofs)        k = REG_EN;
      else if (ofs == pend_ofs) k = REG_PEND;
    end
    return k;
  endfunction

  // Channel index of a byte address.
  function automatic int unsigned decode_chan(input logic [31:0] a, input int stride);
    int unsigned ai;
    ai = a;
    return ai / stride;
  endfunction

endpackage

// File: rtl/irqmux_sync.sv
module irqmux_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irqmux_regs.sv
module irqmux_regs
  import irqmux_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_SRC = 32,
  parameter int BUS_W   = 32,
  parameter int CH_W    = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  reg_kind_e                        wr_kind,
  input  logic [CH_W-1:0]                  wr_ch,
  input  logic [BUS_W-1:0]                 wdata,
  output logic [NUM_CH-1:0][NUM_SRC-1:0]   en_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_en
    logic hit;
    assign hit = wr_en && (wr_kind == REG_EN) && (wr_ch == CH_W'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   en_q[c] <= '0;
      else if (hit) en_q[c] <= wdata[NUM_SRC-1:0];
    end
  end
endmodule

// File: rtl/irqmux_chan.sv
module irqmux_chan #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] sync_src,
  input  logic [NUM_SRC-1:0] en,
  output logic [NUM_SRC-1:0] pend,
  output logic               irq
);
  assign pend = sync_src & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |pend;
  end
endmodule

// File: rtl/irq_fanout_mux.sv
module irq_fanout_mux
  import irqmux_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int NUM_SRC     = 32,
  parameter int BUS_W       = 32,
  parameter int ADDR_W      = 9,
  parameter int STRIDE      = 64,
  parameter int EN_OFS      = 16,
  parameter int PEND_OFS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BUS_W-1:0]   wdata,
  output logic [BUS_W-1:0]   rdata,
  output logic [NUM_CH-1:0]  irq_out
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_SRC-1:0]               sync_src;
  logic [NUM_CH-1:0][NUM_SRC-1:0]   en_q;
  logic [NUM_CH-1:0][NUM_SRC-1:0]   pend_w;
  reg_kind_e                        acc_kind;
  logic [CH_W-1:0]                  acc_ch;

  assign acc_kind = decode_kind(32'(addr), NUM_CH, STRIDE, EN_OFS, PEND_OFS);
  assign acc_ch   = CH_W'(decode_chan(32'(addr), STRIDE));

  irqmux_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q(sync_src)
  );

  irqmux_regs #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .BUS_W(BUS_W), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(acc_kind),
    .wr_ch(acc_ch), .wdata(wdata), .en_q(en_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    irqmux_chan #(.NUM_SRC(NUM_SRC)) u_chan (
      .clk(clk), .rst_n(rst_n), .sync_src(sync_src), .en(en_q[c]),
      .pend(pend_w[c]), .irq(irq_out[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (acc_kind)
        REG_EN:   rdata <= BUS_W'(en_q[acc_ch]);
        REG_PEND: rdata <= BUS_W'(pend_w[acc_ch]);
        default:  rdata <= '0;
      endcase
    end else rdata <= '0;
  end
endmodule

// File: rtl/irqmux_chk.sv
module irqmux_chk
  import irqmux_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_SRC = 32,
  parameter int BUS_W   = 32,
  parameter int CH_W    = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_SRC-1:0]             src_in,
  input logic                           wr_en,
  input logic                           rd_en,
  input logic [BUS_W-1:0]               wdata,
  input logic [BUS_W-1:0]               rdata,
  input logic [NUM_CH-1:0]              irq_out,
  input logic [NUM_CH-1:0][NUM_SRC-1:0] en_q,
  input reg_kind_e                      acc_kind,
  input logic [CH_W-1:0]                acc_ch
);
  // R7
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_kind != REG_EN) |=> $stable(en_q));

  // R7
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_kind == REG_NONE) |=> (rdata == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R1
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && acc_kind == REG_EN && acc_ch == CH_W'(c))
        |=> (en_q[c] == $past(wdata[NUM_SRC-1:0])));

    // R9
    other_chan_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && acc_kind == REG_EN && acc_ch != CH_W'(c)) |=> $stable(en_q[c]));

    // R5
    zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && acc_kind == REG_EN && acc_ch == CH_W'(c) && wdata == '0)
        |=> ##1 !irq_out[c]);

    // R3
    rise_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out[c]) |-> ($past(src_in, 3) != '0));
  end
endmodule

bind irq_fanout_mux irqmux_chk #(
  .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .BUS_W(BUS_W), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .en_q(en_q),
  .acc_kind(acc_kind), .acc_ch(acc_ch)
);

// File: tb/irq_fanout_mux_tb.sv
module irq_fanout_mux_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_fanout_mux u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit [31:0] m_en [8];
  bit [31:0] m_s1, m_s2;
  bit [7:0]  m_irq;
  bit [31:0] m_rd;
  string     m_tag = "R8";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_en[i]) m_en[i] <= 0;
      m_s1 <= 0; m_s2 <= 0; m_irq <= 0; m_rd <= 0;
    end else begin
      int ch;
      int ofs;
      bit aligned;
      ch = int'(addr) / 64;
      ofs = int'(addr) % 64;
      aligned = (addr[1:0] == 2'b00);
      if (rd_en) begin
        if (aligned && ofs == 16) begin m_rd <= m_en[ch]; m_tag <= "R1"; end
        else if (aligned && ofs == 32) begin m_rd <= m_s2 & m_en[ch]; m_tag <= "R2"; end
        else begin m_rd <= 0; m_tag <= "R7"; end
      end else begin
        m_rd <= 0; m_tag <= "R7";
      end
      for (int c = 0; c < 8; c++) m_irq[c] <= |(m_s2 & m_en[c]);
      m_s2 <= m_s1;
      m_s1 <= src_in;
      if (wr_en && aligned && ofs == 16) m_en[ch] <= wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4", {24'h0, irq_out}, {24'h0, m_irq});
      check(m_tag, rdata, m_rd);
    end
  end

  function automatic logic [8:0] en_addr(input int c);
    return 9'(16 + 64 * c);
  endfunction

  function automatic logic [8:0] pend_addr(input int c);
    return 9'(32 + 64 * c);
  endfunction

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8", {24'h0, irq_out}, 32'h0);
    check("R8", rdata, 32'h0);
    bus_read(en_addr(3), v); check("R8", v, 32'h0);

    // R1 write and read back
    bus_write(en_addr(0), 32'h0000_0001);
    bus_read(en_addr(0), v); check("R1", v, 32'h0000_0001);
    bus_write(en_addr(7), 32'hA5A5_0F0F);
    bus_read(en_addr(7), v); check("R1", v, 32'hA5A5_0F0F);
    bus_write(en_addr(7), 32'h0);

    // R3 synchroniser latency
    src_in[0] = 1'b1;
    @(negedge clk); check("R3", {31'h0, irq_out[0]}, 32'h0);
    @(negedge clk); check("R3", {31'h0, irq_out[0]}, 32'h0);
    @(negedge clk); check("R3", {31'h0, irq_out[0]}, 32'h1);

    // R2 pending reflects source AND enable
    bus_read(pend_addr(0), v); check("R2", v, 32'h1);
    bus_read(pend_addr(1), v); check("R2", v, 32'h0);

    // R9 isolation
    bus_write(en_addr(1), 32'h1);
    @(negedge clk);
    check("R9", {24'h0, irq_out}, 32'h3);
    bus_write(en_addr(1), 32'h0);
    @(negedge clk);
    check("R9", {24'h0, irq_out}, 32'h1);
    bus_read(en_addr(0), v); check("R9", v, 32'h1);
    bus_read(pend_addr(0), v); check("R9", v, 32'h1);

    // R7 ignored writes and unmapped reads
    bus_write(pend_addr(0), 32'hFFFF_FFFF);
    bus_write(9'h000, 32'hFFFF_FFFF);
    bus_write(9'h011, 32'hFFFF_FFFF);
    bus_read(en_addr(0), v); check("R7", v, 32'h1);
    bus_read(9'h004, v); check("R7", v, 32'h0);
    bus_read(9'h011, v); check("R7", v, 32'h0);

    // R6 level behaviour
    src_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", {31'h0, irq_out[0]}, 32'h0);
    src_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R6", {31'h0, irq_out[0]}, 32'h1);
    repeat (5) @(negedge clk);
    check("R6", {31'h0, irq_out[0]}, 32'h1);

    // R5 zero mask silences channel while source stays high
    bus_write(en_addr(0), 32'h0);
    @(negedge clk);
    check("R5", {31'h0, irq_out[0]}, 32'h0);
    bus_read(pend_addr(0), v); check("R5", v, 32'h0);

    // Randomised phase checked against the model every clock
    for (int n = 0; n < 3000; n++) begin
      int r;
      int c;
      src_in = $urandom;
      r = $urandom % 8;
      c = $urandom % 8;
      wr_en = 1'b0; rd_en = 1'b0;
      if (r < 2) begin
        addr = en_addr(c);
        wdata = ($urandom % 3 == 0) ? 32'h0 : $urandom;
        wr_en = 1'b1;
      end else if (r == 2) begin
        addr = pend_addr(c);
        wdata = $urandom;
        wr_en = 1'b1;
      end else if (r < 6) begin
        case ($urandom % 3)
          0: addr = en_addr(c);
          1: addr = pend_addr(c);
          default: addr = 9'($urandom);
        endcase
        rd_en = 1'b1;
      end
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule